// File: doc/BRIEF.md
# Store Buffer with High-Water Drain Priority

This block holds stores from the core in a first-in first-out queue and writes them out through a second-level cache port. That port is shared with load misses. The core hands over a store as an address, a data word and a byte mask, using a valid/ready handshake. The block stalls the core by dropping ready when all of its entries are in use. A store is captured at the clock edge straight from the enqueue inputs, so the core can offer a store in the same cycle that it produces the store's data.

In every cycle the block decides which requester owns the single cache request output. At low occupancy, buffered stores wait behind a pending load miss so that loads see short latency. Once the number of buffered stores reaches a fixed high-water level, the oldest store takes the port ahead of any load miss. When no load miss is pending, any buffered store drains whatever the occupancy. The cache accepts a request by raising its ready input. The block reports a taken load miss on a separate strobe, and it exports the current occupancy.

Top module: `store_drain_buffer`

## Requirements
- R1: After synchronous reset, occupancy is 0 and st_ready is 1. With no load miss pending, req_valid is 0.
- R2: st_ready is 0 exactly when occupancy equals DEPTH (default 8). A store offered while st_ready is 0 is not stored: occupancy does not change and that store never appears on the request output.
- R3: Stores leave on the request output strictly in acceptance order. Each carries the address, data and byte mask it was accepted with.
- R4: When ld_req is 1 and occupancy is below HIGH_WATER (default 5), the load owns the port: req_valid=1, req_store=0 (0 encodes a load), req_addr=ld_addr, and ld_taken equals cache_ready.
- R5: When occupancy is at or above HIGH_WATER, the oldest store owns the port even when ld_req is 1: req_store=1 (1 encodes a store) and ld_taken=0.
- R6: When ld_req is 0 and occupancy is non-zero, a store is presented (req_valid=1, req_store=1) at any occupancy level.
- R7: A store accepted in the same cycle that a store drains leaves occupancy unchanged.
- R8: Occupancy rises by one for each accepted store and falls by one for each drained store (req_store=1 with cache_ready=1). With occupancy 0 and no load miss, req_valid is 0.
- R9: While a presented store meets cache_ready=0, it stays in the buffer and is presented again with the same address.
- R10: A store is captured from the enqueue inputs of the cycle in which it is accepted, with no staging register. Offered to an empty buffer with no load pending, it is presented on the request output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Buffer can accept a store this cycle |
| st_addr | input | 32 | Store address |
| st_data | input | 64 | Store data |
| st_mask | input | 8 | Store byte-enable mask |
| ld_req | input | 1 | A load miss is waiting for the cache port |
| ld_addr | input | 32 | Address of the waiting load miss |
| ld_taken | output | 1 | The load miss was accepted by the cache this cycle |
| cache_ready | input | 1 | Cache accepts the presented request this cycle |
| req_valid | output | 1 | A request is presented to the cache |
| req_store | output | 1 | 1: request is a store, 0: request is a load |
| req_addr | output | 32 | Request address |
| req_data | output | 64 | Store data (zero for a load) |
| req_mask | output | 8 | Store byte mask (zero for a load) |
| occupancy | output | 4 | Number of buffered stores |

## Verification
The assertions assume that ld_req and ld_addr stay fixed within a cycle. They also assume that cache_ready depends only on the request currently shown, and not on what the block does at the coming edge. The assertions make no assumption about whether the core retries a refused store. The stimulus changes every input only at the falling clock edge and keeps each load request constant for the whole cycle. It offers stores against a full buffer both with and without a drain in the same cycle, so that refusal and the threshold take-over happen while the inputs are stable.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    parameter int SB_ADDR_W = 32;
    parameter int SB_DATA_W = 64;
    localparam int SB_MASK_W = SB_DATA_W / 8;

    typedef struct packed {
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_DATA_W-1:0] data;
        logic [SB_MASK_W-1:0] mask;
    } sb_entry_t;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LOAD  = 2'd1,
        OWN_STORE = 2'd2
    } port_owner_e;

    // Port ownership: stores yield to loads until the high-water level is hit.
    function automatic port_owner_e pick_owner(input logic have_store,
                                               input logic load_waiting,
                                               input logic above_mark);
        if (have_store && (!load_waiting || above_mark))
            return OWN_STORE;
        else if (load_waiting)
            return OWN_LOAD;
        else
            return OWN_NONE;
    endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  sb_entry_t                    push_entry,
    input  logic                         pop,
    output sb_entry_t                    head_entry,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    sb_entry_t          slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;

    assign full       = (count == FULL_CNT);
    assign empty      = (count == '0);
    assign head_entry = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_entry;
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);
    a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
    a_r3_pop_only_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    a_r7_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> count == $past(count));
    a_r8_push_counts_up: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> count == $past(count) + 1'b1);
    a_r8_pop_counts_down: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/sbuf_arbiter.sv
module sbuf_arbiter
    import sbuf_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int HIGH_WATER = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    input  logic                         empty,
    input  logic                         ld_req,
    input  logic                         cache_ready,
    output port_owner_e                  owner,
    output logic                         pop,
    output logic                         ld_taken
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] MARK_CNT = CNT_W'(HIGH_WATER);

    logic above_mark;

    assign above_mark = (count >= MARK_CNT);

    always_comb begin
        owner    = pick_owner(!empty, ld_req, above_mark);
        pop      = (owner == OWN_STORE) && cache_ready;
        ld_taken = (owner == OWN_LOAD) && cache_ready;
    end

    a_r5_load_blocked_above_mark: assert property (@(posedge clk) disable iff (rst)
        (ld_req && above_mark) |-> !ld_taken);
    a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
        !(pop && ld_taken));

endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer
    import sbuf_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int HIGH_WATER = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         st_valid,
    output logic                         st_ready,
    input  logic [SB_ADDR_W-1:0]         st_addr,
    input  logic [SB_DATA_W-1:0]         st_data,
    input  logic [SB_MASK_W-1:0]         st_mask,
    input  logic                         ld_req,
    input  logic [SB_ADDR_W-1:0]         ld_addr,
    output logic                         ld_taken,
    input  logic                         cache_ready,
    output logic                         req_valid,
    output logic                         req_store,
    output logic [SB_ADDR_W-1:0]         req_addr,
    output logic [SB_DATA_W-1:0]         req_data,
    output logic [SB_MASK_W-1:0]         req_mask,
    output logic [$clog2(DEPTH+1)-1:0]   occupancy
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] MARK_CNT = CNT_W'(HIGH_WATER);

    sb_entry_t    in_entry;
    sb_entry_t    head_entry;
    logic         push;
    logic         pop;
    logic         full;
    logic         empty;
    port_owner_e  owner;

    // Captured straight from the core at the edge: no staging register.
    assign in_entry = '{addr: st_addr, data: st_data, mask: st_mask};
    assign st_ready = !full;
    assign push     = st_valid && !full;

    sbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (in_entry),
        .pop        (pop),
        .head_entry (head_entry),
        .count      (occupancy),
        .full       (full),
        .empty      (empty)
    );

    sbuf_arbiter #(.DEPTH(DEPTH), .HIGH_WATER(HIGH_WATER)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .count       (occupancy),
        .empty       (empty),
        .ld_req      (ld_req),
        .cache_ready (cache_ready),
        .owner       (owner),
        .pop         (pop),
        .ld_taken    (ld_taken)
    );

    always_comb begin
        req_valid = (owner != OWN_NONE);
        req_store = (owner == OWN_STORE);
        if (owner == OWN_STORE) begin
            req_addr = head_entry.addr;
            req_data = head_entry.data;
            req_mask = head_entry.mask;
        end else begin
            req_addr = ld_addr;
            req_data = '0;
            req_mask = '0;
        end
    end

    a_r4_load_wins_below_mark: assert property (@(posedge clk) disable iff (rst)
        (ld_req && occupancy < MARK_CNT) |-> (req_valid && !req_store));
    a_r5_store_wins_above_mark: assert property (@(posedge clk) disable iff (rst)
        (ld_req && occupancy >= MARK_CNT) |-> (req_valid && req_store));
    a_r6_drain_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && occupancy != '0) |-> (req_valid && req_store));
    a_r9_stalled_store_held: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store && !cache_ready) |=>
            (!req_store || req_addr == $past(req_addr)));
    a_r2_ready_tracks_room: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready && !pop) |=> $stable(occupancy));

endmodule

// File: tb/store_drain_buffer_test.sv
module store_drain_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    // Columns: st_valid ld_req cache_ready | exp req_valid req_store st_ready ld_taken | exp occupancy after edge
    localparam logic [10:0] VEC [NVEC] = '{
        11'b100_0010_0001,
        11'b111_1011_0010,
        11'b111_1011_0011,
        11'b101_1110_0011,
        11'b110_1010_0100,
        11'b111_1011_0101,
        11'b011_1110_0100,
        11'b111_1011_0101,
        11'b110_1110_0110,
        11'b100_1110_0111,
        11'b100_1110_1000,
        11'b100_1100_1000,
        11'b111_1100_0111,
        11'b001_1110_0110,
        11'b001_1110_0101,
        11'b001_1110_0100,
        11'b001_1110_0011,
        11'b001_1110_0010,
        11'b001_1110_0001,
        11'b001_1110_0000,
        11'b011_1011_0000,
        11'b000_0010_0000
    };

    logic        clk = 0;
    logic        rst;
    logic        st_valid, st_ready, ld_req, ld_taken, cache_ready;
    logic        req_valid, req_store;
    logic [31:0] st_addr, ld_addr, req_addr;
    logic [63:0] st_data, req_data;
    logic [7:0]  st_mask, req_mask;
    logic [3:0]  occupancy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] mq [0:31];
    int mq_head = 0;
    int mq_tail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_drain_buffer uut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
        .ld_req(ld_req), .ld_addr(ld_addr), .ld_taken(ld_taken),
        .cache_ready(cache_ready), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
        .occupancy(occupancy)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] data_of(input logic [31:0] a);
        return {a, ~a};
    endfunction

    task automatic offer(input logic v, input logic [31:0] a);
        st_valid = v;
        st_addr  = a;
        st_data  = data_of(a);
        st_mask  = a[7:0];
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; offer(0, '0); ld_req = 0; ld_addr = 32'hBEEF0000; cache_ready = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk(occupancy == 0, "R1 occupancy after reset", occupancy, 0);
        chk(st_ready == 1, "R1 ready after reset", st_ready, 1);
        chk(req_valid == 0, "R1 no request after reset", req_valid, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [10:0] v;
            logic [3:0] occ_before;
            string tag;
            v = VEC[i];
            @(negedge clk);
            occ_before = occupancy;
            offer(v[10], 32'h1000 + 32'(i) * 4);
            ld_req = v[9];
            ld_addr = 32'hBEEF0000 + 32'(i);
            cache_ready = v[8];
            #1;
            if (v[9] && occ_before >= 5) tag = "R5";
            else if (v[9]) tag = "R4";
            else if (occ_before != 0) tag = "R6";
            else tag = "R8";
            chk(req_valid == v[7], {tag, " req_valid"}, req_valid, v[7]);
            chk(req_store == v[6], {tag, " req_store"}, req_store, v[6]);
            chk(st_ready == v[5], "R2 st_ready", st_ready, v[5]);
            chk(ld_taken == v[4], {tag, " ld_taken"}, ld_taken, v[4]);
            if (v[7] && !v[6])
                chk(req_addr == ld_addr, "R4 load address", req_addr, ld_addr);
            if (v[6] && v[8]) begin
                chk(req_addr == mq[mq_head], "R3 drain order", req_addr, mq[mq_head]);
                chk(req_data == data_of(mq[mq_head]) && req_mask == mq[mq_head][7:0],
                    "R3 data and mask", req_data, data_of(mq[mq_head]));
                mq_head++;
            end
            if (v[10] && v[5]) begin
                mq[mq_tail] = st_addr;
                mq_tail++;
            end
            @(posedge clk);
            #1;
            if (v[10] && !v[5]) tag = "R2 refused store";
            else if (v[10] && v[6] && v[8]) tag = "R7 push with drain";
            else tag = "R8 occupancy";
            chk(occupancy == v[3:0], tag, occupancy, v[3:0]);
        end

        // R10: store into an empty buffer is presented the next cycle
        @(negedge clk);
        offer(1, 32'hA000); ld_req = 0; cache_ready = 0;
        #1;
        chk(st_ready == 1, "R10 ready on empty", st_ready, 1);
        @(negedge clk);
        offer(0, 32'h0);
        #1;
        chk(req_valid && req_store && req_addr == 32'hA000, "R10 presented next cycle", req_addr, 32'hA000);

        // R9: stalled store is held
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(req_store && req_addr == 32'hA000, "R9 held address", req_addr, 32'hA000);
            chk(occupancy == 1, "R9 not removed", occupancy, 1);
        end
        @(negedge clk);
        cache_ready = 1;
        @(posedge clk);
        #1;
        chk(occupancy == 0, "R8 drained after stall", occupancy, 0);

        // R1: reset with stores buffered
        @(negedge clk);
        cache_ready = 0;
        for (int k = 0; k < 3; k++) begin
            offer(1, 32'hC000 + 32'(k));
            @(negedge clk);
        end
        offer(0, 32'h0);
        chk(occupancy == 3, "R8 filled before reset", occupancy, 3);
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        chk(occupancy == 0, "R1 occupancy after mid-run reset", occupancy, 0);
        chk(st_ready == 1 && req_valid == 0, "R1 outputs after mid-run reset", {st_ready, req_valid}, 2'b10);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule